// File: doc/BRIEF.md
# DMA channel transfer sequencer

One channel of a DMA controller. Software sets up a configuration word, a 16-bit transfer count and two 32-bit base addresses: one for the peripheral side and one for the memory side. After the channel is enabled, each transaction that an external arbiter grants is made of two beats on a simple master port. The first beat reads a data item from the source side. The second beat writes that item to the destination side. The working addresses advance by the item size of their side, and the remaining count steps down by one after each transaction.

Circular mode restarts the buffer without help from software. The channel raises one-cycle pulses when the transfer is half done, when it is complete, and when the bus reports an error. The master port uses valid/ready handshaking. A beat holds `m_valid`, `m_addr`, `m_write`, `m_size` and `m_wdata` unchanged until the cycle in which `m_ready` is high. The slave may hold `m_ready` low for as many cycles as it needs. `m_err` is only looked at in the cycle in which a beat is accepted.

Top module: `dma_chan_seq`

## Requirements
- R1: Registers by `reg_addr`:
  - 0 is the configuration word: bit0 enable, bit1 direction, bit2 circular, bit3 peripheral increment, bit4 memory increment, bits 6:5 peripheral size, bits 8:7 memory size, bit9 memory-to-memory.
  - 1 is the remaining count.
  - 2 is the peripheral base.
  - 3 is the memory base.
  - `reg_rdata` shows the addressed register at once, with unused high bits zero. After reset every register is zero, `m_valid` is low and no event pulses.
- R2: A write to register 1, 2 or 3 is ignored while the enable bit is 1 or a transaction is in flight. While the enable bit is 0 and the channel is idle, such a write sets both the stored value and the working value.
- R3: A transaction reads (`m_write`=0) from the source and then writes (`m_write`=1) to the destination. Direction 0 means peripheral to memory; direction 1 means memory to peripheral. The written data is the read data masked to the source item size.
- R4: A transaction starts only when all of these hold: the enable bit is 1, the remaining count is nonzero, `grant` is high, and `periph_req` is high. In memory-to-memory mode the `periph_req` condition is dropped.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_wdata` hold their values.
- R6: Size code 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. `m_size` carries the code of the side being accessed. `m_addr` has bit 0 forced to zero for code 01, and bits 1:0 forced to zero for codes 10 and 11.
- R7: After each completed transaction, a side whose increment bit is set advances its working address by 1, 2 or 4, according to its size code. Reading a base register returns the programmed value.
- R8: The remaining count drops by one when the write beat is accepted without error. In normal mode it then stays at zero.
- R9: In circular mode, when the count reaches zero, the count reloads the last programmed value and both working addresses return to their bases.
- R10: `evt_half` pulses when the count after a decrement equals the programmed count divided by two (rounded down). `evt_done` pulses when the count after a decrement is zero. Both pulses fall in the cycle after the accepting edge.
- R11: A beat accepted with `m_err` high ends the transaction without changing the count or the addresses. It pulses `evt_err` in the next cycle and clears the enable bit, and this clear takes priority over a configuration write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| periph_req | input | 1 | Peripheral asks for a transaction |
| grant | input | 1 | Arbiter grants this channel |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Slave accepts the beat |
| m_write | output | 1 | Beat is a write |
| m_addr | output | 32 | Aligned beat address |
| m_size | output | 2 | Size code of the beat |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, taken when a read beat is accepted |
| m_err | input | 1 | Error response on the accepted beat |
| evt_half | output | 1 | Half-transfer pulse |
| evt_done | output | 1 | Transfer-complete pulse |
| evt_err | output | 1 | Transfer-error pulse |

## Verification
The cycle timing that the checks follow is:
- `m_valid` rises one cycle after the edge at which the start conditions are sampled.
- The write beat follows in the cycle after the read beat is accepted.
- The count, the working addresses and the three event pulses change at the edge that accepts the write beat (or the failing beat), so they are visible in the following cycle.
- Register writes show up on `reg_rdata` in the cycle after the write edge.

The bench model advances its state at every rising edge from the same sampled inputs. It compares every output and the addressed register at the falling edge, so each expected value is sampled in the cycle in which it is due. Inputs change one nanosecond after the rising edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_RSV = 2'b11
  } xfer_size_e;

  // bit 0 is the enable, bit 9 is memory-to-memory
  typedef struct packed {
    logic       m2m;
    xfer_size_e msize;
    xfer_size_e psize;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
    logic       en;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    RA_CFG   = 2'd0,
    RA_CNT   = 2'd1,
    RA_PADDR = 2'd2,
    RA_MADDR = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  localparam int SIDE_PER = 0;
  localparam int SIDE_MEM = 1;
  localparam int NSIDES   = 2;

  function automatic logic [2:0] size_step(input xfer_size_e s);
    case (s)
      SZ_8:    return 3'd1;
      SZ_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] low_clear(input xfer_size_e s);
    case (s)
      SZ_8:    return 2'b00;
      SZ_16:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic [AW-1:0] base,
  input  xfer_size_e    sz,
  input  logic          inc,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (ld)      cur <= ld_val;
    else if (adv) begin
      if (wrap)       cur <= base;
      else if (inc)   cur <= cur + AW'(size_step(sz));
    end
  end

  assign addr = cur & ~AW'(low_clear(sz));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [1:0]             reg_addr,
  input  logic [AW-1:0]          reg_wdata,
  output logic [AW-1:0]          reg_rdata,
  input  logic                   busy,
  input  logic                   err_clr,
  input  logic [CW-1:0]          rem_cnt,
  output chan_cfg_t              cfg,
  output logic [CW-1:0]          prog_cnt,
  output logic [NSIDES-1:0][AW-1:0] base,
  output logic                   ld_cnt,
  output logic [NSIDES-1:0]      ld_addr
);

  localparam int CFGW = $bits(chan_cfg_t);

  logic locked;
  assign locked     = cfg.en | busy;
  assign ld_cnt     = reg_we && reg_addr == RA_CNT   && !locked;
  assign ld_addr[SIDE_PER] = reg_we && reg_addr == RA_PADDR && !locked;
  assign ld_addr[SIDE_MEM] = reg_we && reg_addr == RA_MADDR && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      prog_cnt <= '0;
      base     <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CFG) cfg <= chan_cfg_t'(reg_wdata[CFGW-1:0]);
      if (err_clr)                      cfg.en <= 1'b0;
      if (ld_cnt)                       prog_cnt <= reg_wdata[CW-1:0];
      for (int s = 0; s < NSIDES; s++)
        if (ld_addr[s]) base[s] <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CFG:   reg_rdata = AW'(cfg);
      RA_CNT:   reg_rdata = AW'(rem_cnt);
      RA_PADDR: reg_rdata = base[SIDE_PER];
      default:  reg_rdata = base[SIDE_MEM];
    endcase
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  chan_cfg_t                 cfg,
  input  logic [CW-1:0]             prog_cnt,
  input  logic [NSIDES-1:0][AW-1:0] base,
  input  logic                      ld_cnt,
  input  logic [NSIDES-1:0]         ld_addr,
  input  logic [AW-1:0]             ld_val,
  input  logic                      periph_req,
  input  logic                      grant,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic                      m_write,
  output logic [AW-1:0]             m_addr,
  output logic [1:0]                m_size,
  output logic [DW-1:0]             m_wdata,
  input  logic [DW-1:0]             m_rdata,
  input  logic                      m_err,
  output logic [CW-1:0]             rem_cnt,
  output logic                      busy,
  output logic                      err_clr,
  output logic                      evt_half,
  output logic                      evt_done,
  output logic                      evt_err
);

  seq_state_e    state;
  logic [DW-1:0] data_q;
  logic [AW-1:0] side_addr [NSIDES];
  logic          src, dst;
  xfer_size_e    src_sz, dst_sz;
  logic          start, acc, beat_ok, beat_bad, last_wr, wrap;
  logic [CW-1:0] rem_next;
  logic [DW-1:0] lane;

  assign src    = cfg.dir;          // 1 selects the memory side as source
  assign dst    = ~cfg.dir;
  assign src_sz = cfg.dir ? cfg.msize : cfg.psize;
  assign dst_sz = cfg.dir ? cfg.psize : cfg.msize;

  assign start    = (state == ST_IDLE) && cfg.en && (rem_cnt != '0)
                    && (cfg.m2m || periph_req) && grant;
  assign acc      = m_valid && m_ready;
  assign beat_ok  = acc && !m_err;
  assign beat_bad = acc && m_err;
  assign last_wr  = (state == ST_WRITE) && beat_ok;
  assign rem_next = rem_cnt - CW'(1);
  assign wrap     = cfg.circ && (rem_next == '0);

  for (genvar g = 0; g < NSIDES; g++) begin : g_side
    xfer_size_e sz_g;
    logic       inc_g;
    assign sz_g  = (g == SIDE_PER) ? cfg.psize : cfg.msize;
    assign inc_g = (g == SIDE_PER) ? cfg.pinc  : cfg.minc;
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_addr[g]),
      .ld_val (ld_val),
      .base   (base[g]),
      .sz     (sz_g),
      .inc    (inc_g),
      .adv    (last_wr),
      .wrap   (wrap),
      .addr   (side_addr[g])
    );
  end

  always_comb begin
    case (src_sz)
      SZ_8:    lane = DW'(8'hFF);
      SZ_16:   lane = DW'(16'hFFFF);
      default: lane = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_READ;
        ST_READ:  if (beat_bad) state <= ST_IDLE;
                  else if (beat_ok) state <= ST_WRITE;
        ST_WRITE: if (acc) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      rem_cnt  <= '0;
      evt_half <= 1'b0;
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
    end else begin
      if (state == ST_READ && beat_ok) data_q <= m_rdata & lane;
      if (ld_cnt)       rem_cnt <= ld_val[CW-1:0];
      else if (last_wr) rem_cnt <= wrap ? prog_cnt : rem_next;
      evt_half <= last_wr && (rem_next == (prog_cnt >> 1));
      evt_done <= last_wr && (rem_next == '0);
      evt_err  <= beat_bad;
    end
  end

  assign m_valid = (state != ST_IDLE);
  assign m_write = (state == ST_WRITE);
  assign m_addr  = m_write ? side_addr[dst] : side_addr[src];
  assign m_size  = m_write ? dst_sz : src_sz;
  assign m_wdata = data_q;
  assign busy    = (state != ST_IDLE);
  assign err_clr = beat_bad;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          periph_req,
  input  logic          grant,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_err,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err
);

  chan_cfg_t                 cfg;
  logic [CW-1:0]             prog_cnt, rem_cnt;
  logic [NSIDES-1:0][AW-1:0] base;
  logic                      ld_cnt, busy, err_clr;
  logic [NSIDES-1:0]         ld_addr;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .err_clr   (err_clr),
    .rem_cnt   (rem_cnt),
    .cfg       (cfg),
    .prog_cnt  (prog_cnt),
    .base      (base),
    .ld_cnt    (ld_cnt),
    .ld_addr   (ld_addr)
  );

  dma_chan_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .prog_cnt   (prog_cnt),
    .base       (base),
    .ld_cnt     (ld_cnt),
    .ld_addr    (ld_addr),
    .ld_val     (reg_wdata),
    .periph_req (periph_req),
    .grant      (grant),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_write    (m_write),
    .m_addr     (m_addr),
    .m_size     (m_size),
    .m_wdata    (m_wdata),
    .m_rdata    (m_rdata),
    .m_err      (m_err),
    .rem_cnt    (rem_cnt),
    .busy       (busy),
    .err_clr    (err_clr),
    .evt_half   (evt_half),
    .evt_done   (evt_done),
    .evt_err    (evt_err)
  );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          periph_req,
  input logic          grant,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_write,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_size,
  input logic [DW-1:0] m_wdata,
  input logic          m_err,
  input logic          evt_half,
  input logic          evt_done,
  input logic          evt_err,
  input chan_cfg_t     cfg,
  input logic [CW-1:0] rem_cnt
);

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata));

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(cfg.en && grant && (rem_cnt != '0) && (periph_req || cfg.m2m)));

  // R6
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_size == 2'b01 |-> !m_addr[0]);

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_size[1] |-> m_addr[1:0] == 2'b00);

  // R11
  err_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_err |=> !cfg.en && evt_err && $stable(rem_cnt));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_write && m_ready && !m_err && !cfg.circ |=> rem_cnt == $past(rem_cnt) - CW'(1));

  // R2
  count_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd1 && cfg.en && !m_valid |=> $stable(rem_cnt));

  // R10
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_err && (evt_done || evt_half)));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .periph_req (periph_req),
  .grant      (grant),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_write    (m_write),
  .m_addr     (m_addr),
  .m_size     (m_size),
  .m_wdata    (m_wdata),
  .m_err      (m_err),
  .evt_half   (evt_half),
  .evt_done   (evt_done),
  .evt_err    (evt_err),
  .cfg        (cfg),
  .rem_cnt    (rem_cnt)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          periph_req = 1'b0, grant = 1'b0;
  logic          m_valid, m_write, m_ready = 1'b1, m_err;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          evt_half, evt_done, evt_err;

  always #2 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .grant(grant), .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_err(m_err), .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err)
  );

  int checks = 0, errors = 0, cyc = 0, wd = 0;
  bit stall = 0, err_on = 0;
  logic [AW-1:0] err_addr = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction
  function automatic logic [31:0] align(input logic [31:0] a, input logic [1:0] s);
    return (s == 2'b00) ? a : (s == 2'b01) ? (a & ~32'h1) : (a & ~32'h3);
  endfunction
  function automatic int unsigned stepof(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction
  function automatic logic [31:0] lmask(input logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign m_rdata = pat(m_addr);
  assign m_err   = err_on && m_valid && m_write && (m_addr == err_addr);

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    m_ready = !stall || (cyc % 3 != 1);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int unsigned mst, mrem, mprog;
  logic [31:0] mbase [2], mwork [2], mdata;
  logic [9:0]  mcfg;
  bit          xh, xd, xe;

  always @(posedge clk) begin
    int src, dst;
    bit en, busy, clr;
    logic [1:0] ssz [2];
    bit inc [2];
    if (!rst_n) begin
      mst = 0; mrem = 0; mprog = 0; mcfg = '0; mdata = '0;
      mbase[0] = '0; mbase[1] = '0; mwork[0] = '0; mwork[1] = '0;
      xh = 0; xd = 0; xe = 0;
    end else begin
      src = int'(mcfg[1]); dst = 1 - src;
      en = mcfg[0]; busy = (mst != 0); clr = 0;
      ssz[0] = mcfg[6:5]; ssz[1] = mcfg[8:7];
      inc[0] = mcfg[3];   inc[1] = mcfg[4];
      xh = 0; xd = 0; xe = 0;
      case (mst)
        0: if (en && mrem != 0 && (mcfg[9] || periph_req) && grant) mst = 1;
        1: if (m_ready) begin
             if (m_err) begin xe = 1; clr = 1; mst = 0; end
             else begin
               mdata = pat(align(mwork[src], ssz[src])) & lmask(ssz[src]);
               mst = 2;
             end
           end
        default: if (m_ready) begin
             if (m_err) begin xe = 1; clr = 1; mst = 0; end
             else begin
               mrem = mrem - 1;
               xh = (mrem == mprog / 2);
               xd = (mrem == 0);
               if (mrem == 0 && mcfg[2]) begin
                 mrem = mprog; mwork[0] = mbase[0]; mwork[1] = mbase[1];
               end else begin
                 for (int k = 0; k < 2; k++)
                   if (inc[k]) mwork[k] = mwork[k] + stepof(ssz[k]);
               end
               mst = 0;
             end
           end
      endcase
      if (reg_we) begin
        if (reg_addr == 2'd0) mcfg = reg_wdata[9:0];
        else if (!en && !busy) begin
          if (reg_addr == 2'd1) begin mrem = reg_wdata[15:0]; mprog = reg_wdata[15:0]; end
          else begin
            mbase[reg_addr - 2] = reg_wdata;
            mwork[reg_addr - 2] = reg_wdata;
          end
        end
      end
      if (clr) mcfg[0] = 1'b0;
    end
  end

  // bookkeeping of observed traffic
  int nvalid = 0, nwr = 0, nhalf = 0, ndone = 0, nerr = 0;
  logic [31:0] last_wa = '0, last_ra = '0, last_wd = '0;

  always @(negedge clk) begin
    logic [31:0] ea, er;
    int s, d;
    if (rst_n) begin
      s = int'(mcfg[1]); d = 1 - s;
      chk("R5 m_valid vs model", 32'(m_valid), 32'(mst != 0));
      if (mst != 0) begin
        ea = (mst == 2) ? align(mwork[d], (d == 0) ? mcfg[6:5] : mcfg[8:7])
                        : align(mwork[s], (s == 0) ? mcfg[6:5] : mcfg[8:7]);
        chk("R6,R7 m_addr vs model", m_addr, ea);
        chk("R3 m_write vs model", 32'(m_write), 32'(mst == 2));
        if (mst == 2) chk("R3 m_wdata vs model", m_wdata, mdata);
      end
      chk("R10 evt_half vs model", 32'(evt_half), 32'(xh));
      chk("R10 evt_done vs model", 32'(evt_done), 32'(xd));
      chk("R11 evt_err vs model", 32'(evt_err), 32'(xe));
      case (reg_addr)
        2'd0:    er = {22'd0, mcfg};
        2'd1:    er = mrem;
        2'd2:    er = mbase[0];
        default: er = mbase[1];
      endcase
      chk("R1,R2 reg_rdata vs model", reg_rdata, er);
      if (m_valid) nvalid++;
      if (m_valid && m_ready && m_write && !m_err) begin
        nwr++; last_wa = m_addr; last_wd = m_wdata;
      end
      if (m_valid && m_ready && !m_write && !m_err) last_ra = m_addr;
      if (evt_half) nhalf++;
      if (evt_done) ndone++;
      if (evt_err)  nerr++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=%0d cycles expected=below 20000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic clear_stats();
    nvalid = 0; nwr = 0; nhalf = 0; ndone = 0; nerr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 m_valid after reset", 32'(m_valid), 32'd0);
    rreg(2'd0, 32'd0, "R1 config after reset");
    rreg(2'd1, 32'd0, "R1 count after reset");
    rreg(2'd2, 32'd0, "R1 periph base after reset");
    rreg(2'd3, 32'd0, "R1 memory base after reset");

    // peripheral to memory, 16-bit fixed source, 32-bit incrementing destination
    wreg(2'd2, 32'h4000_1003);
    wreg(2'd3, 32'h2000_0001);
    wreg(2'd1, 32'd4);
    periph_req = 1'b1; grant = 1'b1;
    clear_stats();
    wreg(2'd0, 32'h131);
    repeat (40) @(posedge clk);
    rreg(2'd1, 32'd0, "R8 count stays zero");
    chk("R10 one done pulse", ndone, 32'd1);
    chk("R10 one half pulse", nhalf, 32'd1);
    chk("R6 last source addr aligned", last_ra, 32'h4000_1002);
    chk("R7 last destination addr", last_wa, 32'h2000_000C);
    chk("R3 data masked to 16 bits", last_wd, pat(32'h4000_1002) & 32'hFFFF);
    rreg(2'd3, 32'h2000_0001, "R7 memory base unchanged");

    // locked writes while enabled, and no work at zero count
    wreg(2'd1, 32'd9);
    rreg(2'd1, 32'd0, "R2 count write ignored while enabled");
    wreg(2'd2, 32'h0000_1234);
    rreg(2'd2, 32'h4000_1003, "R2 periph base write ignored while enabled");
    clear_stats();
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R4 no beat at zero count", nvalid, 32'd0);

    // grant withheld
    wreg(2'd0, 32'h0);
    wreg(2'd1, 32'd2);
    grant = 1'b0;
    clear_stats();
    wreg(2'd0, 32'h131);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R4 no beat without grant", nvalid, 32'd0);
    @(posedge clk); #1 grant = 1'b1;
    repeat (20) @(posedge clk);
    rreg(2'd1, 32'd0, "R8 granted transfer drains count");

    // circular memory-to-memory, memory to peripheral, stalled slave
    wreg(2'd0, 32'h0);
    wreg(2'd2, 32'h3000_0000);
    wreg(2'd3, 32'h1000_0010);
    wreg(2'd1, 32'd3);
    periph_req = 1'b0; stall = 1;
    clear_stats();
    wreg(2'd0, 32'h21F);
    while (nwr < 5) @(posedge clk);
    #1 grant = 1'b0;
    repeat (4) @(posedge clk);
    rreg(2'd1, 32'd1, "R9 count reloaded in circular mode");
    chk("R9 one done pulse over five", ndone, 32'd1);
    chk("R10 half pulses over five", nhalf, 32'd2);
    chk("R9 destination restarted at base", last_wa, 32'h3000_0001);
    chk("R3 source on memory side", last_ra, 32'h1000_0011);
    chk("R3 data masked to 8 bits", last_wd, pat(32'h1000_0011) & 32'hFF);

    // bus error on third write
    stall = 0; grant = 1'b1; periph_req = 1'b1;
    wreg(2'd0, 32'h0);
    wreg(2'd2, 32'h5000_0000);
    wreg(2'd3, 32'h6000_0000);
    wreg(2'd1, 32'd6);
    err_addr = 32'h6000_0008; err_on = 1;
    clear_stats();
    wreg(2'd0, 32'h159);
    repeat (40) @(posedge clk);
    chk("R11 one error pulse", nerr, 32'd1);
    chk("R11 no done after error", ndone, 32'd0);
    rreg(2'd0, 32'h158, "R11 enable cleared by error");
    rreg(2'd1, 32'd4, "R11 count keeps failed transaction");
    err_on = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule